// File: doc/BRIEF.md
# Graphic Display Half-Panel Controller

This block is the device-side controller for one 64-column half of a monochrome graphic panel. A host drives a simple parallel port: a one-cycle strobe together with a data/instruction select, a read/write select and an input byte. The block decodes instruction bytes into its pointer and control registers. It moves data bytes into and out of a display memory of 8 pages by 64 columns, where each byte holds 8 vertically stacked pixels. It also answers status polls with a three-flag byte.

A separate read-only scan port lets a refresh unit fetch any byte of the display memory without disturbing the host pointers. The block presents the display-enable flag and the start line so that the refresh unit can decide what to show and from which row. Each accepted host access holds a busy flag for a fixed number of cycles. While that flag is set, only status polls are honoured.

Top module: `glcd_half_ctrl`

## Requirements
- R1: Instruction byte 0011111b (b in bit 0) sets disp_on to b. It changes no memory byte, and it leaves the column pointer, the page pointer and start_line unchanged.
- R2: Instruction byte 01cccccc loads the column pointer with cccccc (bits 5:0). The next data access uses that column.
- R3: Instruction byte 10111ppp loads the page pointer with ppp (bits 2:0). Every following data access uses that page until the pointer is loaded again.
- R4: Instruction byte 11ssssss loads the start line with ssssss. The new value appears on start_line after the accepting clock edge.
- R5: A data write (bus_di=1, bus_rw=0) stores bus_din at memory byte (page, column). It then advances the column pointer by one.
- R6: A data read (bus_di=1, bus_rw=1) places the addressed byte on bus_dout after the accepting edge. It also advances the column pointer by one.
- R7: Column 63 steps to column 0 on a data access, and the page pointer keeps its value.
- R8: A status read (bus_di=0, bus_rw=1) is honoured even while busy. It places a byte on bus_dout in which bit 7 is busy, bit 5 is 1 when the display is off, bit 4 is 1 while rst is high, and all other bits are 0. It does not itself start a busy period.
- R9: Each accepted instruction or data access holds busy for BUSY_CYCLES cycles. Strobes other than status reads that arrive while busy is set have no effect.
- R10: While rst is high, the column pointer, page pointer and start line are zero and the display is off. Strobes other than status reads are ignored.
- R11: scan_byte always shows the memory byte at (scan_page, scan_col). A host write to that byte becomes visible there after its accepting edge.
- R12: Instruction bytes that match none of the four instruction patterns change no register and no memory byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| bus_strobe | input | 1 | One-cycle access request |
| bus_di | input | 1 | 1 = data access, 0 = instruction/status |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_din | input | 8 | Byte written by the host |
| bus_dout | output | 8 | Byte returned by the last read or status poll |
| scan_page | input | 3 | Refresh fetch page |
| scan_col | input | 6 | Refresh fetch column |
| scan_byte | output | 8 | Memory byte at the refresh address |
| disp_on | output | 1 | Display enable |
| start_line | output | 6 | Row shown at the top of the panel |

## Verification
A host data write and a refresh fetch can address the same memory byte in the same cycle. The bench points the scan port at the byte about to be written, then raises the write strobe. It expects the old byte on scan_byte before the edge and the new byte one edge later. A second overlap is a status poll that falls inside a busy window. The bench polls on every cycle after an access and expects the busy bit on exactly BUSY_CYCLES polls. It also expects a data write placed inside the window to leave neither the memory nor the column pointer changed.

// File: rtl/glcd_pkg.sv
package glcd_pkg;
  localparam int COL_W  = 6;
  localparam int PAGE_W = 3;
  localparam int NCOLS  = 1 << COL_W;
  localparam int NPAGES = 1 << PAGE_W;
  localparam int ADDR_W = COL_W + PAGE_W;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_DISP  = 3'd1,
    OP_COL   = 3'd2,
    OP_PAGE  = 3'd3,
    OP_START = 3'd4
  } op_e;

  typedef struct packed {
    op_e              op;
    logic             on_bit;
    logic [COL_W-1:0] arg;
  } instr_t;

  function automatic logic [COL_W-1:0] col_step(input logic [COL_W-1:0] c);
    return c + COL_W'(1);
  endfunction

  function automatic instr_t decode_instr(input logic [7:0] b);
    instr_t r;
    r.op     = OP_NONE;
    r.on_bit = b[0];
    r.arg    = b[COL_W-1:0];
    if (b[7:1] == 7'b0011111)      r.op = OP_DISP;
    else if (b[7:6] == 2'b01)      r.op = OP_COL;
    else if (b[7:3] == 5'b10111)   r.op = OP_PAGE;
    else if (b[7:6] == 2'b11)      r.op = OP_START;
    return r;
  endfunction

  function automatic logic [7:0] pack_status(input logic busy, input logic off,
                                             input logic in_rst);
    return {busy, 1'b0, off, in_rst, 4'b0000};
  endfunction
endpackage

// File: rtl/glcd_decode.sv
module glcd_decode
  import glcd_pkg::*;
(
  input  logic       strobe,
  input  logic       di,
  input  logic       rw,
  input  logic [7:0] din,
  input  logic       busy,
  input  logic       rst,
  output logic       status_rd,
  output logic       acc_wr,
  output logic       acc_rd,
  output logic       acc_cmd,
  output logic       start_busy,
  output instr_t     instr
);
  logic live;

  assign status_rd  = strobe & ~di & rw;
  assign live       = strobe & ~busy & ~rst;
  assign acc_wr     = live & di & ~rw;
  assign acc_rd     = live & di & rw;
  assign acc_cmd    = live & ~di & ~rw;
  assign start_busy = acc_wr | acc_rd | acc_cmd;
  assign instr      = decode_instr(din);
endmodule

// File: rtl/glcd_busy.sv
module glcd_busy #(
  parameter int BUSY_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (start)        cnt <= CW'(BUSY_CYCLES);
    else if (cnt != '0)    cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);

  assert_busy_after_access_R9: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
  assert_busy_drains_R9: assert property (@(posedge clk) disable iff (rst)
    (!start && cnt == CW'(1)) |=> !busy);
endmodule

// File: rtl/glcd_ram.sv
module glcd_ram
  import glcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] host_page,
  input  logic [COL_W-1:0]  host_col,
  input  logic [7:0]        wr_data,
  output logic [7:0]        host_q,
  input  logic [PAGE_W-1:0] scan_page,
  input  logic [COL_W-1:0]  scan_col,
  output logic [7:0]        scan_q
);
  logic [7:0]        mem [NPAGES*NCOLS];
  logic [ADDR_W-1:0] host_addr;
  logic [ADDR_W-1:0] scan_addr;

  assign host_addr = {host_page, host_col};
  assign scan_addr = {scan_page, scan_col};

  always_ff @(posedge clk) begin
    if (wr_en) mem[host_addr] <= wr_data;
  end

  assign host_q = mem[host_addr];
  assign scan_q = mem[scan_addr];

  assert_scan_sees_write_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && scan_addr == host_addr) |=> (scan_addr != $past(scan_addr)) || (scan_q == $past(wr_data)));
endmodule

// File: rtl/glcd_half_ctrl.sv
module glcd_half_ctrl
  import glcd_pkg::*;
#(
  parameter int BUSY_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_strobe,
  input  logic              bus_di,
  input  logic              bus_rw,
  input  logic [7:0]        bus_din,
  output logic [7:0]        bus_dout,
  input  logic [PAGE_W-1:0] scan_page,
  input  logic [COL_W-1:0]  scan_col,
  output logic [7:0]        scan_byte,
  output logic              disp_on,
  output logic [COL_W-1:0]  start_line
);
  logic              status_rd, acc_wr, acc_rd, acc_cmd, start_busy, busy;
  instr_t            instr;
  logic [COL_W-1:0]  col;
  logic [PAGE_W-1:0] page;
  logic [7:0]        ram_q;
  logic              data_acc;

  glcd_decode u_decode (
    .strobe(bus_strobe), .di(bus_di), .rw(bus_rw), .din(bus_din),
    .busy(busy), .rst(rst), .status_rd(status_rd), .acc_wr(acc_wr),
    .acc_rd(acc_rd), .acc_cmd(acc_cmd), .start_busy(start_busy), .instr(instr)
  );

  glcd_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst(rst), .start(start_busy), .busy(busy)
  );

  glcd_ram u_ram (
    .clk(clk), .rst(rst), .wr_en(acc_wr), .host_page(page), .host_col(col),
    .wr_data(bus_din), .host_q(ram_q), .scan_page(scan_page),
    .scan_col(scan_col), .scan_q(scan_byte)
  );

  assign data_acc = acc_wr | acc_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      col        <= '0;
      page       <= '0;
      start_line <= '0;
      disp_on    <= 1'b0;
    end else begin
      if (acc_cmd) begin
        case (instr.op)
          OP_DISP:  disp_on    <= instr.on_bit;
          OP_COL:   col        <= instr.arg;
          OP_PAGE:  page       <= instr.arg[PAGE_W-1:0];
          OP_START: start_line <= instr.arg;
          default:  ;
        endcase
      end
      if (data_acc) col <= col_step(col);
    end
  end

  always_ff @(posedge clk) begin
    if (status_rd)   bus_dout <= pack_status(busy, ~disp_on, rst);
    else if (rst)    bus_dout <= '0;
    else if (acc_rd) bus_dout <= ram_q;
  end

  assert_disp_keeps_pointers_R1: assert property (@(posedge clk) disable iff (rst)
    (acc_cmd && instr.op == OP_DISP) |=> ($stable(col) && $stable(page) && $stable(start_line)));
  assert_wrap_to_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (data_acc && col == '1) |=> (col == '0));
  assert_page_holds_on_data_R7: assert property (@(posedge clk) disable iff (rst)
    data_acc |=> $stable(page));
  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe && busy && !status_rd) |=>
      ($stable(col) && $stable(page) && $stable(start_line) && $stable(disp_on)));
  assert_status_zero_bits_R8: assert property (@(posedge clk) disable iff (rst)
    status_rd |=> (bus_dout[6] == 1'b0 && bus_dout[3:0] == 4'b0000));
endmodule

// File: tb/glcd_half_ctrl_tb.sv
`timescale 1ns/1ps
module glcd_half_ctrl_tb;
  localparam int BUSY = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_strobe = 1'b0, bus_di = 1'b0, bus_rw = 1'b0;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout;
  logic [2:0] scan_page = '0;
  logic [5:0] scan_col = '0;
  logic [7:0] scan_byte;
  logic       disp_on;
  logic [5:0] start_line;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [512];
  int m_page = 0, m_col = 0;

  glcd_half_ctrl #(.BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst(rst), .bus_strobe(bus_strobe), .bus_di(bus_di),
    .bus_rw(bus_rw), .bus_din(bus_din), .bus_dout(bus_dout),
    .scan_page(scan_page), .scan_col(scan_col), .scan_byte(scan_byte),
    .disp_on(disp_on), .start_line(start_line)
  );

  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat(input int p, input int c);
    return 8'((p * 29 + c * 7 + 3) & 255) ^ 8'h5A;
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // caller stands at a negedge; returns at a negedge with busy drained
  task automatic access(input logic di, input logic rw, input logic [7:0] d,
                        output logic [7:0] q);
    bus_strobe = 1'b1; bus_di = di; bus_rw = rw; bus_din = d;
    @(negedge clk);
    q = bus_dout;
    bus_strobe = 1'b0;
    repeat (BUSY) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] d);
    logic [7:0] q;
    access(1'b0, 1'b0, d, q);
    if (d[7:6] == 2'b01) m_col = int'(d[5:0]);
    if (d[7:3] == 5'b10111) m_page = int'(d[2:0]);
  endtask

  task automatic wr(input logic [7:0] d);
    logic [7:0] q;
    access(1'b1, 1'b0, d, q);
    mdl[m_page * 64 + m_col] = d;
    m_col = (m_col + 1) % 64;
  endtask

  task automatic rd(output logic [7:0] q);
    access(1'b1, 1'b1, 8'h00, q);
    m_col = (m_col + 1) % 64;
  endtask

  task automatic status(output logic [7:0] q);
    bus_strobe = 1'b1; bus_di = 1'b0; bus_rw = 1'b1;
    @(negedge clk);
    q = bus_dout;
    bus_strobe = 1'b0;
  endtask

  task automatic scan_chk(input string req, input int p, input int c, input logic [7:0] exp);
    scan_page = 3'(p); scan_col = 6'(c);
    #0.1;
    check8(req, scan_byte, exp);
  endtask

  initial begin
    repeat (BUSY * 60000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] q;
    repeat (3) @(negedge clk);
    // R10 reset state, R8 status format during reset
    check8("R10 disp_on in reset", {7'b0, disp_on}, 8'h00);
    check8("R10 start_line in reset", {2'b0, start_line}, 8'h00);
    status(q);
    check8("R8 R10 status in reset", q, 8'h30);
    rst = 1'b0;
    @(negedge clk);
    status(q);
    check8("R8 status idle off", q, 8'h20);

    // R1 display on
    cmd(8'h3F);
    check8("R1 display on", {7'b0, disp_on}, 8'h01);
    status(q);
    check8("R8 status idle on", q, 8'h00);

    // R4 start line sweep
    for (int v = 0; v < 64; v++) begin
      cmd(8'hC0 | 8'(v));
      check8("R4 start line", {2'b0, start_line}, 8'(v));
    end
    cmd(8'hC0 | 8'h15);

    // R3 R5 full write sweep
    for (int p = 0; p < 8; p++) begin
      cmd(8'hB8 | 8'(p));
      cmd(8'h40);
      for (int c = 0; c < 64; c++) wr(pat(p, c));
    end
    for (int p = 0; p < 8; p++)
      for (int c = 0; c < 64; c++)
        scan_chk("R3 R5 R11 sweep", p, c, mdl[p * 64 + c]);

    // R6 R7 read back page 3 with wrap
    cmd(8'hBB);
    cmd(8'h40);
    for (int c = 0; c < 65; c++) begin
      rd(q);
      check8("R6 R7 read back", q, pat(3, c % 64));
    end

    // R7 write wrap on page 5
    cmd(8'hBD);
    cmd(8'h40 | 8'd62);
    wr(8'hA1); wr(8'hA2); wr(8'hA3);
    scan_chk("R7 wrap col62", 5, 62, 8'hA1);
    scan_chk("R7 wrap col63", 5, 63, 8'hA2);
    scan_chk("R7 wrap col0 same page", 5, 0, 8'hA3);
    scan_chk("R7 next page untouched", 6, 0, pat(6, 0));

    // R2 column set
    cmd(8'hBA);
    cmd(8'h40 | 8'd17);
    wr(8'h5C);
    scan_chk("R2 column load", 2, 17, 8'h5C);
    scan_chk("R2 neighbour", 2, 18, pat(2, 18));

    // R1 off/on keep pointers and memory
    cmd(8'hB9);
    cmd(8'h40 | 8'd30);
    cmd(8'h3E);
    check8("R1 display off", {7'b0, disp_on}, 8'h00);
    scan_chk("R1 memory kept", 1, 30, pat(1, 30));
    cmd(8'h3F);
    wr(8'h77);
    scan_chk("R1 column kept", 1, 30, 8'h77);
    check8("R1 start kept", {2'b0, start_line}, 8'h15);

    // R12 unrecognised codes
    cmd(8'hBC);
    cmd(8'h40 | 8'd40);
    cmd(8'h3D); cmd(8'h80); cmd(8'h00); cmd(8'hB0);
    wr(8'h99);
    scan_chk("R12 pointers unchanged", 4, 40, 8'h99);
    scan_chk("R12 memory unchanged", 4, 41, pat(4, 41));
    check8("R12 disp_on unchanged", {7'b0, disp_on}, 8'h01);
    check8("R12 start unchanged", {2'b0, start_line}, 8'h15);

    // R9 R8 busy polling after a write to (4,41)
    bus_strobe = 1'b1; bus_di = 1'b1; bus_rw = 1'b0; bus_din = 8'h3C;
    mdl[4 * 64 + 41] = 8'h3C; m_col = 42;
    @(negedge clk);
    bus_di = 1'b0; bus_rw = 1'b1;
    for (int k = 1; k <= BUSY + 1; k++) begin
      @(negedge clk);
      check8("R9 R8 busy poll", bus_dout, (k <= BUSY) ? 8'h80 : 8'h00);
    end
    @(negedge clk);
    check8("R8 poll starts no busy", bus_dout, 8'h00);
    bus_strobe = 1'b0;

    // R9 write inside busy window ignored
    bus_strobe = 1'b1; bus_di = 1'b1; bus_rw = 1'b0; bus_din = 8'hD1;
    @(negedge clk);
    bus_din = 8'hD2;
    @(negedge clk);
    bus_strobe = 1'b0;
    repeat (BUSY) @(negedge clk);
    wr(8'hD3);
    scan_chk("R9 first write", 4, 42, 8'hD1);
    scan_chk("R9 busy write ignored", 4, 43, 8'hD3);
    scan_chk("R9 column not advanced", 4, 44, pat(4, 44));

    // R11 same-cycle host write and scan fetch
    cmd(8'hB8);
    cmd(8'h40 | 8'd7);
    scan_page = 3'd0; scan_col = 6'd7;
    bus_strobe = 1'b1; bus_di = 1'b1; bus_rw = 1'b0; bus_din = 8'hE5;
    #0.1;
    check8("R11 scan old before edge", scan_byte, pat(0, 7));
    @(negedge clk);
    check8("R11 scan new after edge", scan_byte, 8'hE5);
    bus_strobe = 1'b0;
    repeat (BUSY) @(negedge clk);

    // R10 second reset: write during reset ignored, pointers cleared
    rst = 1'b1;
    bus_strobe = 1'b1; bus_di = 1'b1; bus_rw = 1'b0; bus_din = 8'hEE;
    @(negedge clk);
    bus_strobe = 1'b0;
    @(negedge clk);
    status(q);
    check8("R10 R8 status in reset", q, 8'h30);
    check8("R10 start cleared", {2'b0, start_line}, 8'h00);
    check8("R10 display off", {7'b0, disp_on}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    scan_chk("R10 write in reset ignored", 0, 0, pat(0, 0));
    m_page = 0; m_col = 0;
    wr(8'h11);
    scan_chk("R10 pointers zero", 0, 0, 8'h11);
    scan_chk("R10 next column", 0, 1, pat(0, 1));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule